// File: doc/BRIEF.md
# Two-Button Bounded Up/Down Counter

This block holds a 9-bit count steered by two raw push-button inputs, one meant to raise the count and one meant to lower it. Each button input is brought into the clock domain through a multi-stage synchroniser. It is then filtered by a stable-time debouncer and reduced to a single-cycle event on the moment the button becomes pressed. One clocked process owns the count and updates it from the two events.

The count does not wrap. Near each end it turns back instead. A raise event on a count above the upper turn point (399) lowers the count. A lower event on a count below the lower turn point (200) raises it. Starting from zero, the count therefore stays between 0 and 400. Everything runs on one clock with a synchronous active-high reset. The interface is plain control pins with no handshake, because there is no data stream: the count is a level that is always valid.

Top module: `dual_key_counter`

## Requirements
- R1: While reset is high and on the cycle after it falls, the count reads 0.
- R2: Buttons are active high (1 = pressed). Each raw input passes a SYNC_STAGES-flop synchroniser. A change in the synchronised level is accepted only after it has held for STABLE_CYCLES consecutive clocks. A shorter pulse or bounce leaves the count unchanged.
- R3: An accepted up press with the count at or below 399 adds one to the count.
- R4: An accepted up press with the count above 399 subtracts one from the count.
- R5: An accepted down press with the count below 200 adds one to the count.
- R6: An accepted down press with the count at or above 200 subtracts one from the count.
- R7: A press produces one event however long the button is held. An event lasts one cycle, and releasing the button has no effect on the count.
- R8: If up and down events occur in the same cycle, the count holds.
- R9: The count changes by at most one per cycle, and only in the cycle after an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_up_raw | input | 1 | Raw up button, asynchronous, 1 = pressed |
| key_dn_raw | input | 1 | Raw down button, asynchronous, 1 = pressed |
| count | output | CNT_W (9) | Current count |

## Verification
The hardest states to reach from the pins are the two turn points, above all the upper one. It takes 400 fully debounced presses to get there, and every press costs a hold time and a release time. The bench shrinks the stable time to a few cycles and walks a vector table whose rows repeat one press pattern hundreds of times. This drives the count to 399/400 and then back down through 200/199, so it can check the behaviour on both sides of each threshold. Simultaneous presses are produced by raising both buttons on the same clock, so that both debouncers accept on the same edge.

// File: rtl/dkc_pkg.sv
package dkc_pkg;
  localparam int KEY_UP   = 0;
  localparam int KEY_DN   = 1;
  localparam int NUM_KEYS = 2;
endpackage

// File: rtl/dkc_sync.sv
module dkc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/dkc_debounce.sv
module dkc_debounce #(
  parameter int STABLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic press_evt
);
  localparam int RUN_W = $clog2(STABLE_CYCLES + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(STABLE_CYCLES - 1);

  logic             held_q;
  logic [RUN_W-1:0] run_q;
  logic             evt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b0;
      run_q  <= '0;
      evt_q  <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (level_in == held_q) begin
        run_q <= '0;
      end else if (run_q == RUN_LAST) begin
        held_q <= level_in;
        run_q  <= '0;
        evt_q  <= level_in;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign press_evt = evt_q;
endmodule

// File: rtl/dkc_count_core.sv
module dkc_count_core #(
  parameter int CNT_W   = 9,
  parameter int UP_TURN = 399,
  parameter int DN_TURN = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_evt,
  input  logic             dn_evt,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] UP_EDGE = CNT_W'(UP_TURN);
  localparam logic [CNT_W-1:0] DN_EDGE = CNT_W'(DN_TURN);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      unique case ({up_evt, dn_evt})
        2'b10:   cnt_q <= (cnt_q > UP_EDGE) ? cnt_q - 1'b1 : cnt_q + 1'b1;
        2'b01:   cnt_q <= (cnt_q < DN_EDGE) ? cnt_q + 1'b1 : cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/dual_key_counter.sv
module dual_key_counter #(
  parameter int CNT_W         = 9,
  parameter int SYNC_STAGES   = 2,
  parameter int STABLE_CYCLES = 50000,
  parameter int UP_TURN       = 399,
  parameter int DN_TURN       = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_up_raw,
  input  logic             key_dn_raw,
  output logic [CNT_W-1:0] count
);
  import dkc_pkg::*;

  logic [NUM_KEYS-1:0] raw_keys;
  logic [NUM_KEYS-1:0] synced_keys;
  logic [NUM_KEYS-1:0] press;
  logic                up_evt;
  logic                dn_evt;

  always_comb begin
    raw_keys         = '0;
    raw_keys[KEY_UP] = key_up_raw;
    raw_keys[KEY_DN] = key_dn_raw;
  end

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    dkc_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk (clk),
      .rst (rst),
      .din (raw_keys[k]),
      .dout(synced_keys[k])
    );
    dkc_debounce #(.STABLE_CYCLES(STABLE_CYCLES)) deb_i (
      .clk      (clk),
      .rst      (rst),
      .level_in (synced_keys[k]),
      .press_evt(press[k])
    );
  end

  assign up_evt = press[KEY_UP];
  assign dn_evt = press[KEY_DN];

  dkc_count_core #(
    .CNT_W  (CNT_W),
    .UP_TURN(UP_TURN),
    .DN_TURN(DN_TURN)
  ) core_i (
    .clk   (clk),
    .rst   (rst),
    .up_evt(up_evt),
    .dn_evt(dn_evt),
    .count (count)
  );
endmodule

// File: rtl/dual_key_counter_chk.sv
module dual_key_counter_chk #(
  parameter int CNT_W   = 9,
  parameter int UP_TURN = 399,
  parameter int DN_TURN = 200
) (
  input logic             clk,
  input logic             rst,
  input logic             up_evt,
  input logic             dn_evt,
  input logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] UP_EDGE = CNT_W'(UP_TURN);
  localparam logic [CNT_W-1:0] DN_EDGE = CNT_W'(DN_TURN);

  logic rst_seen_q;
  always_ff @(posedge clk) begin
    rst_seen_q <= rst;
    if (rst_seen_q) begin
      p_reset_clear_r1: assert (count == '0)
        else $error("count not cleared by reset");
    end
  end

  p_up_rise_r3: assert property (@(posedge clk) disable iff (rst)
    (up_evt && !dn_evt && count <= UP_EDGE) |=> (count == $past(count) + 1'b1));

  p_up_turn_r4: assert property (@(posedge clk) disable iff (rst)
    (up_evt && !dn_evt && count > UP_EDGE) |=> (count + 1'b1 == $past(count)));

  p_dn_rise_r5: assert property (@(posedge clk) disable iff (rst)
    (dn_evt && !up_evt && count < DN_EDGE) |=> (count == $past(count) + 1'b1));

  p_dn_fall_r6: assert property (@(posedge clk) disable iff (rst)
    (dn_evt && !up_evt && count >= DN_EDGE) |=> (count + 1'b1 == $past(count)));

  p_up_single_r7: assert property (@(posedge clk) disable iff (rst)
    up_evt |=> !up_evt);

  p_dn_single_r7: assert property (@(posedge clk) disable iff (rst)
    dn_evt |=> !dn_evt);

  p_both_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (up_evt && dn_evt) |=> $stable(count));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!up_evt && !dn_evt) |=> $stable(count));
endmodule

bind dual_key_counter dual_key_counter_chk #(
  .CNT_W  (CNT_W),
  .UP_TURN(UP_TURN),
  .DN_TURN(DN_TURN)
) chk_i (
  .clk   (clk),
  .rst   (rst),
  .up_evt(up_evt),
  .dn_evt(dn_evt),
  .count (count)
);

// File: tb/dual_key_counter_tb_top.sv
`timescale 1ns/1ps
module dual_key_counter_tb_top;
  localparam int CNT_W  = 9;
  localparam int STABLE = 4;
  localparam int HOLD   = STABLE + 8;
  localparam int NVEC   = 14;
  // columns: button code (1 up, 2 down, 3 both), presses, expected count
  localparam int VEC [NVEC][3] = '{
    '{1,   3,   3},  // R3 climb from zero
    '{2,   1,   4},  // R5 down below 200 raises
    '{3,   2,   4},  // R8 simultaneous presses hold
    '{1, 395, 399},  // R3 climb to the upper turn point
    '{1,   1, 400},  // R3 at 399 still raises
    '{1,   1, 399},  // R4 above 399 lowers
    '{1,   1, 400},  // R3 back up
    '{2,   1, 399},  // R6 down at or above 200 lowers
    '{2, 199, 200},  // R6 walk down to 200
    '{2,   1, 199},  // R6 at 200 lowers
    '{2,   1, 200},  // R5 at 199 raises
    '{2,   1, 199},  // R6 again
    '{3,   1, 199},  // R8 hold near lower turn point
    '{1,   1, 200}   // R3 up from 199
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             key_up_raw = 1'b0;
  logic             key_dn_raw = 1'b0;
  logic [CNT_W-1:0] count;
  int               n_checks = 0;
  int               n_errors = 0;
  int               cycles = 0;

  always #2.5 clk = ~clk;

  dual_key_counter #(
    .CNT_W(CNT_W), .SYNC_STAGES(2), .STABLE_CYCLES(STABLE),
    .UP_TURN(399), .DN_TURN(200)
  ) dut_i (
    .clk(clk), .rst(rst), .key_up_raw(key_up_raw),
    .key_dn_raw(key_dn_raw), .count(count)
  );

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: count %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(int code);
    key_up_raw = code[0];
    key_dn_raw = code[1];
    idle(HOLD);
    key_up_raw = 1'b0;
    key_dn_raw = 1'b0;
    idle(HOLD);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_errors++;
      $display("FAIL watchdog: cycles %0d expected below %0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    check("R1 during reset", int'(count), 0);
    rst = 1'b0;
    idle(1);
    check("R1 after reset", int'(count), 0);

    for (int v = 0; v < NVEC; v++) begin
      for (int p = 0; p < VEC[v][1]; p++) press(VEC[v][0]);
      check($sformatf("vector %0d", v), int'(count), VEC[v][2]);
    end

    // R2: glitch one cycle shorter than the stable time is ignored
    key_up_raw = 1'b1;
    idle(STABLE - 1);
    key_up_raw = 1'b0;
    idle(HOLD);
    check("R2 short glitch ignored", int'(count), 200);

    // R2/R7: bouncing then steady press gives exactly one step
    for (int b = 0; b < 5; b++) begin
      key_dn_raw = 1'b1; idle(2);
      key_dn_raw = 1'b0; idle(2);
    end
    key_dn_raw = 1'b1;
    idle(HOLD);
    check("R2 bounce filtered to one step", int'(count), 199);

    // R7: long hold adds nothing, release adds nothing
    idle(100);
    check("R7 long hold single step", int'(count), 199);
    key_dn_raw = 1'b0;
    idle(HOLD);
    check("R7 release no effect", int'(count), 199);

    // R9: quiet inputs keep the count
    idle(50);
    check("R9 idle stable", int'(count), 199);

    // R1: reset in mid-run clears the count
    rst = 1'b1;
    idle(3);
    check("R1 mid-run reset", int'(count), 0);
    rst = 1'b0;
    idle(2);
    press(1);
    check("R3 after reset", int'(count), 1);

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule